// File: doc/BRIEF.md
# Fractional MAC with Scale-Round Writeback

This block multiplies two signed 1.15 fractions and folds the product into a 40-bit accumulator in one clock. Each operand is one 16-bit half of a 32-bit source word. A control bit per operand picks the upper or the lower half. The product is aligned as a fraction, meaning it is doubled, and is then loaded into the accumulator, added to it or subtracted from it.

On the same clock edge the block produces a 16-bit writeback value from the new accumulator. It doubles the accumulator, rounds to the upper half of the 32-bit scaled value and clamps the result to the signed 16-bit range. That value replaces the lower half of the destination word. The upper half is passed through from the `dst_in` input. The accumulator itself keeps the unscaled sum, and its low 32 bits are visible at all times as a word.

The design has no control sequence. Every accepted operation completes in the cycle it is presented, so the block holds no states and no transitions beyond the accumulator and destination registers.

Top module: `fmac_s2rnd_unit`

## Requirements
- R1: After reset, `acc_word` and `dst_out` read 0x00000000.
- R2: Half selection: when `sel_a_hi` is 1 the operand is `src_a[31:16]`, and when it is 0 the operand is `src_a[15:0]`. `sel_b_hi` selects from `src_b` in the same way.
- R3: The product is the signed 16x16 product shifted left by one bit, sign-extended to 40 bits. `acc_word` shows accumulator bits [31:0]. For example, 0xFEC7 times 0x5ABD, loaded, reads 0xFF221DD6.
- R4: When both operands are 0x8000, the aligned product is forced to 0x7FFFFFFF.
- R5: `op_code` 2'b00 loads the product, 2'b01 adds it and 2'b10 subtracts it. Add and subtract wrap modulo 2^40 and do not stop at 32 bits.
- R6: The writeback value comes from the updated accumulator. The accumulator is doubled, 0x8000 is added, and bits [31:16] of that 32-bit-aligned sum are kept, so ties round up. For example, accumulator 0xFF221DD6 writes 0xFE44.
- R7: If the rounded value is above 32767 the writeback is 0x7FFF. If it is below -32768 the writeback is 0x8000.
- R8: An accepted operation sets `dst_out` to {`dst_in[31:16]`, writeback} on the same edge that updates the accumulator.
- R9: While `op_valid` is 0, `acc_word` and `dst_out` keep their values.
- R10: `op_code` 2'b11 is reserved. With `op_valid` high it leaves the accumulator and `dst_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 2 | 00 load, 01 add, 10 subtract, 11 reserved |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| sel_a_hi | input | 1 | Selects the upper half of src_a |
| sel_b_hi | input | 1 | Selects the upper half of src_b |
| dst_in | input | 32 | Current destination word; its upper half is kept |
| dst_out | output | 32 | Updated destination word |
| acc_word | output | 32 | Accumulator bits [31:0] |

## Verification
Directed cases isolate single effects:
- The 0x8000 squared case separates the clamped product from a plain doubled product.
- Two tie values, one positive and one negative, show whether rounding goes up or goes toward zero.
- Full-scale products push the writeback into both clamp levels.

A long run of maximal adds drives the accumulator across bit 39. This shows whether the sum wraps at 40 bits or stops at 32. Seeded random sources, half selects and operation codes, including the reserved code and idle cycles, exercise the load, add and subtract mix against a bench model. The random run also catches swapped half selection and a destination half written in the wrong place.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 40;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_RSVD = 2'b11
    } acc_op_e;
endpackage

// File: rtl/fmac_half_pick.sv
module fmac_half_pick #(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              take_hi_i,
    output logic [HALF_W-1:0] half_o
);
    always_comb begin
        if (take_hi_i) half_o = word_i[WORD_W-1 -: HALF_W];
        else           half_o = word_i[HALF_W-1:0];
    end
endmodule

// File: rtl/fmac_frac_mul.sv
module fmac_frac_mul #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   op_a_i,
    input  logic [HALF_W-1:0]   op_b_i,
    output logic [2*HALF_W-1:0] prod_o
);
    localparam int PROD_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] MIN_FRAC = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [PROD_W-1:0] MAX_PROD = {1'b0, {(PROD_W-1){1'b1}}};

    logic signed [PROD_W-1:0] raw;
    logic                     corner;

    always_comb begin
        raw    = $signed(op_a_i) * $signed(op_b_i);
        corner = (op_a_i == MIN_FRAC) && (op_b_i == MIN_FRAC);
        if (corner) prod_o = MAX_PROD;
        else        prod_o = {raw[PROD_W-2:0], 1'b0};
    end

    // R3 R4
    always_comb begin
        prod_align_chk: assert (prod_o[0] == 1'b0 || prod_o == MAX_PROD)
            else $error("aligned product has odd LSB");
    end
endmodule

// File: rtl/fmac_round_sat.sv
module fmac_round_sat #(
    parameter int ACC_W  = 40,
    parameter int HALF_W = 16
) (
    input  logic [ACC_W-1:0]  acc_i,
    output logic [HALF_W-1:0] wb_o
);
    localparam int SC_W  = ACC_W + 2;
    localparam int TOP_W = SC_W - HALF_W;
    localparam logic signed [SC_W-1:0]  RND_ADD = SC_W'(1) <<< (HALF_W - 1);
    localparam logic signed [TOP_W-1:0] POS_LIM = TOP_W'((1 <<< (HALF_W - 1)) - 1);
    localparam logic signed [TOP_W-1:0] NEG_LIM = -TOP_W'(1 <<< (HALF_W - 1));
    localparam logic [HALF_W-1:0] SAT_POS = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] SAT_NEG = {1'b1, {(HALF_W-1){1'b0}}};

    logic signed [SC_W-1:0]  scaled;
    logic signed [TOP_W-1:0] upper;

    always_comb begin
        scaled = $signed({acc_i[ACC_W-1], acc_i, 1'b0}) + RND_ADD;
        upper  = scaled[SC_W-1:HALF_W];
        if (upper > POS_LIM)      wb_o = SAT_POS;
        else if (upper < NEG_LIM) wb_o = SAT_NEG;
        else                      wb_o = upper[HALF_W-1:0];
    end

    // R7
    always_comb begin
        sat_sign_chk: assert (!(wb_o == SAT_NEG && !acc_i[ACC_W-1]))
            else $error("negative clamp from non-negative accumulator");
    end
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum
    import fmac_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int PROD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  acc_op_e           op_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic [ACC_W-1:0]  acc_next_o,
    output logic [ACC_W-1:0]  acc_q_o
);
    logic [ACC_W-1:0] prod_ext;

    always_comb begin
        prod_ext = {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
        unique case (op_i)
            OP_LOAD: acc_next_o = prod_ext;
            OP_ADD:  acc_next_o = acc_q_o + prod_ext;
            OP_SUB:  acc_next_o = acc_q_o - prod_ext;
            default: acc_next_o = acc_q_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc_q_o <= '0;
        else if (en_i) acc_q_o <= acc_next_o;
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_q_o));
    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_LOAD) |=> acc_q_o == $past(prod_ext));
endmodule

// File: rtl/fmac_s2rnd_unit.sv
module fmac_s2rnd_unit
    import fmac_pkg::*;
#(
    parameter int WORD_W = fmac_pkg::WORD_W,
    parameter int HALF_W = fmac_pkg::HALF_W,
    parameter int ACC_W  = fmac_pkg::ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic              sel_a_hi,
    input  logic              sel_b_hi,
    input  logic [WORD_W-1:0] dst_in,
    output logic [WORD_W-1:0] dst_out,
    output logic [WORD_W-1:0] acc_word
);
    localparam int PROD_W = 2 * HALF_W;
    localparam int N_SRC  = 2;

    logic [N_SRC-1:0][WORD_W-1:0] src_words;
    logic [N_SRC-1:0]             src_hi;
    logic [N_SRC-1:0][HALF_W-1:0] halves;
    logic [PROD_W-1:0]            prod;
    logic [ACC_W-1:0]             acc_next;
    logic [ACC_W-1:0]             acc_q;
    logic [HALF_W-1:0]            wb_half;
    acc_op_e                      op;
    logic                         take;

    assign src_words = {src_b, src_a};
    assign src_hi    = {sel_b_hi, sel_a_hi};
    assign op        = acc_op_e'(op_code);
    assign take      = op_valid && (op != OP_RSVD);

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_pick
        fmac_half_pick #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_pick (
            .word_i    (src_words[gi]),
            .take_hi_i (src_hi[gi]),
            .half_o    (halves[gi])
        );
    end

    fmac_frac_mul #(.HALF_W(HALF_W)) u_mul (
        .op_a_i (halves[0]),
        .op_b_i (halves[1]),
        .prod_o (prod)
    );

    fmac_accum #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (take),
        .op_i       (op),
        .prod_i     (prod),
        .acc_next_o (acc_next),
        .acc_q_o    (acc_q)
    );

    fmac_round_sat #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_rnd (
        .acc_i (acc_next),
        .wb_o  (wb_half)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dst_out <= '0;
        else if (take) dst_out <= {dst_in[WORD_W-1:HALF_W], wb_half};
    end

    assign acc_word = acc_q[WORD_W-1:0];

    // R8
    dst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> dst_out[WORD_W-1:HALF_W] == $past(dst_in[WORD_W-1:HALF_W]));
    // R10
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'b11) |=> ($stable(dst_out) && $stable(acc_word)));
    // R9
    idle_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(dst_out));
endmodule

// File: tb/fmac_s2rnd_unit_test.sv
module fmac_s2rnd_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] src_a = '0, src_b = '0, dst_in = '0;
    logic        sel_a_hi = 1'b0, sel_b_hi = 1'b0;
    logic [31:0] dst_out, acc_word;

    int n_run = 0;
    int n_fail = 0;
    logic signed [39:0] m_acc = '0;
    logic [31:0]        m_dst = '0;

    always #5 clk = ~clk;

    fmac_s2rnd_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
        .dst_in(dst_in), .dst_out(dst_out), .acc_word(acc_word)
    );

    function automatic logic [31:0] f_prod(logic [15:0] a, logic [15:0] b);
        logic signed [31:0] p;
        if (a == 16'h8000 && b == 16'h8000) return 32'h7FFFFFFF;
        p = $signed(a) * $signed(b);
        return p <<< 1;
    endfunction

    function automatic logic [15:0] f_wb(logic signed [39:0] acc);
        longint s;
        longint h;
        s = (longint'(acc) * 2) + 64'sd32768;
        h = s >>> 16;
        if (h > 32767)  return 16'h7FFF;
        if (h < -32768) return 16'h8000;
        return h[15:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_op(logic [1:0] code, logic [31:0] a, logic [31:0] b,
                         logic ah, logic bh, logic [31:0] d, logic vld, string req);
        logic [15:0] ha, hb;
        logic signed [39:0] pe;
        @(negedge clk);
        op_code = code; src_a = a; src_b = b; sel_a_hi = ah; sel_b_hi = bh;
        dst_in = d; op_valid = vld;
        ha = ah ? a[31:16] : a[15:0];
        hb = bh ? b[31:16] : b[15:0];
        pe = 40'(signed'(f_prod(ha, hb)));
        if (vld && code != 2'b11) begin
            case (code)
                2'b00:   m_acc = pe;
                2'b01:   m_acc = m_acc + pe;
                default: m_acc = m_acc - pe;
            endcase
            m_dst = {d[31:16], f_wb(m_acc)};
        end
        @(negedge clk);
        op_valid = 1'b0;
        check(req, acc_word, m_acc[31:0]);
        check(req, dst_out, m_dst);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 acc", acc_word, 32'h0);
        check("R1 dst", dst_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R6: worked example
        do_op(2'b00, 32'h83545ABD, 32'h98BCFEC7, 1'b0, 1'b0, 32'h12340000, 1'b1, "R3 R6 load");
        check("R3 word", acc_word, 32'hFF221DD6);
        check("R6 wb", dst_out, 32'h1234FE44);
        // R2: upper halves 0x4000 * 0x4000 -> 0x20000000
        do_op(2'b00, 32'h4000_0001, 32'h4000_0003, 1'b1, 1'b1, 32'h0, 1'b1, "R2 hi");
        check("R2 hi", acc_word, 32'h20000000);
        do_op(2'b00, 32'h4000_0002, 32'h4000_0003, 1'b0, 1'b0, 32'h0, 1'b1, "R2 lo");
        check("R2 lo", acc_word, 32'h0000000C);
        // R4
        do_op(2'b00, 32'h00008000, 32'h80000000, 1'b0, 1'b1, 32'hAAAA5555, 1'b1, "R4");
        check("R4 corner", acc_word, 32'h7FFFFFFF);
        check("R7 pos clamp", dst_out, 32'hAAAA7FFF);
        // R6 ties: +0x4000 -> 0x0001, -0x4000 -> 0x0000
        do_op(2'b00, 32'h00000001, 32'h00002000, 1'b0, 1'b0, 32'hFFFF0000, 1'b1, "R6 tie+");
        check("R6 tie+", dst_out, 32'hFFFF0001);
        do_op(2'b00, 32'h0000FFFF, 32'h00002000, 1'b0, 1'b0, 32'hFFFF0000, 1'b1, "R6 tie-");
        check("R6 tie-", dst_out, 32'hFFFF0000);
        // R7 negative clamp
        do_op(2'b00, 32'h00008000, 32'h00007FFF, 1'b0, 1'b0, 32'h0, 1'b1, "R7 neg");
        check("R7 neg clamp", dst_out, 32'h00008000);
        // R5 subtract then wrap past bit 39
        do_op(2'b10, 32'h00004000, 32'h00004000, 1'b0, 1'b0, 32'h0, 1'b1, "R5 sub");
        do_op(2'b00, 32'h00007FFF, 32'h00007FFF, 1'b0, 1'b0, 32'h0, 1'b1, "R5 wrap");
        for (int i = 0; i < 300; i++)
            do_op(2'b01, 32'h00007FFF, 32'h00007FFF, 1'b0, 1'b0, 32'h0, 1'b1, "R5 wrap");
        check("R5 wrapped negative", dst_out, 32'h00008000);
        // R9 idle, R10 reserved
        do_op(2'b00, 32'h7FFF7FFF, 32'h7FFF7FFF, 1'b1, 1'b0, 32'h55550000, 1'b0, "R9 idle");
        do_op(2'b11, 32'h7FFF7FFF, 32'h12345678, 1'b0, 1'b1, 32'h55550000, 1'b1, "R10 rsvd");
        // R8 random mix
        for (int i = 0; i < 400; i++)
            do_op(2'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
                  $urandom, ($urandom % 5) != 0, "R8 random");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule